// File: doc/BRIEF.md
# Pairwise Distance Histogram Engine

This block builds a weighted histogram of the distances between every distinct pair of particles. Each particle is stored on chip as three unsigned 16-bit coordinates in picometres and a signed weight. Software loads the particles through a simple write port, sets the particle count and pulses `start`. The engine then forms each pair, takes the integer square root of the squared separation and adds the product of the two weights into the bin whose index is that distance in whole picometres.

A parameter `UF` sets how many lanes run in parallel. Each lane owns a private histogram, so lanes never contend for one memory. For each test particle, the partners that follow it are handed out `UF` at a time. The few partners left over at the end of that row are handed out one by one. When all pairs have drained through the pipeline, the private histograms are added bin by bin into a result histogram. `done` is then raised, and the result is read by address with one cycle of latency.

Top module: `pdh_engine`

## Requirements
- R1: The bin index of a pair is floor(sqrt(dx²+dy²+dz²)). Here dx, dy and dz are the absolute differences of the unsigned 16-bit coordinates, so the full coordinate range is handled.
- R2: Each pair adds the product of its two signed `WW`-bit weights (two's complement) into its bin. Each bin is a signed 32-bit sum. A bin that receives no pair reads zero.
- R3: Only pairs (j, i) with j < i < `n_part` are counted, and each is counted exactly once. A run with `n_part` of 0 or 1 yields an all-zero histogram.
- R4: While at least `UF` partners remain for a test particle, `UF` consecutive partners are issued in one cycle, one per lane.
- R5: When fewer than `UF` partners remain for a test particle, they are issued one per cycle, on lane 0 only.
- R6: A pair whose distance is `NBINS` or more adds nothing to any bin.
- R7: Pairs arriving back to back at the same bin are all accumulated; none is lost to a stale read.
- R8: Every start clears all histograms, so nothing from an earlier run remains in the result.
- R9: A start accepted while idle makes `busy` high and `done` low on the next cycle. `done` rises only after the lane histograms have been combined. It then stays high until the next start and is never high together with `busy`.
- R10: `rd_data` presents result bin `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Write one particle into the particle store |
| ld_addr | input | log2(N_MAX) | Particle slot to write |
| ld_x | input | CW | X coordinate, picometres, unsigned |
| ld_y | input | CW | Y coordinate, picometres, unsigned |
| ld_z | input | CW | Z coordinate, picometres, unsigned |
| ld_w | input | WW | Signed particle weight |
| start | input | 1 | Begin a run when idle |
| n_part | input | log2(N_MAX)+1 | Number of particles used by the run, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result histogram valid |
| rd_addr | input | log2(NBINS) | Result bin to read |
| rd_data | output | AW | Signed sum of the addressed bin, one cycle later |

## Verification
The main function is swept over particle counts from 0 to the store depth. This makes every remainder of the partner count modulo `UF` appear, including rows made only of full groups and rows made only of single partners. Random clouds spread pairs over many bins and separate an error in the distance from an error in the weight product. Coincident particles send every pair to bin 0 on consecutive cycles, which exposes any lost read-modify-write update. A widely spaced line and a mix of extreme corners show whether far pairs are dropped and whether the absolute difference is right near 65,535. Running an empty count right after a full run shows whether the histograms are cleared between runs.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_PAIR,
    ST_DRAIN,
    ST_RED
  } pdh_state_e;

endpackage

// File: rtl/pdh_isqrt.sv
// Pipelined integer square root, one result bit per stage, floor rounding.
module pdh_isqrt #(
  parameter int IN_W  = 34,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic [IN_W-1:0]  in_rad,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_v,
  output logic [IN_W/2-1:0] out_root,
  output logic [TAG_W-1:0] out_tag
);
  localparam int RT_W = IN_W / 2;

  logic             st_v    [RT_W];
  logic [IN_W-1:0]  st_rad  [RT_W];
  logic [RT_W-1:0]  st_rem  [RT_W];
  logic [RT_W-1:0]  st_root [RT_W];
  logic [TAG_W-1:0] st_tag  [RT_W];
  logic [RT_W+1:0]  cur     [RT_W];
  logic [RT_W+1:0]  sub     [RT_W];
  logic [RT_W+1:0]  dif     [RT_W];
  logic             fits    [RT_W];

  logic             q_v    [RT_W];
  logic [IN_W-1:0]  q_rad  [RT_W];
  logic [RT_W-1:0]  q_rem  [RT_W];
  logic [RT_W-1:0]  q_root [RT_W];
  logic [TAG_W-1:0] q_tag  [RT_W];

  always_comb begin
    st_v[0]    = in_v;
    st_rad[0]  = in_rad;
    st_rem[0]  = '0;
    st_root[0] = '0;
    st_tag[0]  = in_tag;
    for (int s = 1; s < RT_W; s++) begin
      st_v[s]    = q_v[s-1];
      st_rad[s]  = q_rad[s-1];
      st_rem[s]  = q_rem[s-1];
      st_root[s] = q_root[s-1];
      st_tag[s]  = q_tag[s-1];
    end
    for (int s = 0; s < RT_W; s++) begin
      cur[s]  = {st_rem[s], st_rad[s][IN_W-1-2*s -: 2]};
      sub[s]  = {st_root[s], 2'b01};
      fits[s] = (cur[s] >= sub[s]);
      dif[s]  = cur[s] - sub[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < RT_W; s++) q_v[s] <= 1'b0;
    end else begin
      for (int s = 0; s < RT_W; s++) q_v[s] <= st_v[s];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < RT_W; s++) begin
      q_rad[s]  <= st_rad[s];
      q_rem[s]  <= fits[s] ? dif[s][RT_W-1:0] : cur[s][RT_W-1:0];
      q_root[s] <= {st_root[s][RT_W-2:0], fits[s]};
      q_tag[s]  <= st_tag[s];
    end
  end

  assign out_v    = q_v[RT_W-1];
  assign out_root = q_root[RT_W-1];
  assign out_tag  = q_tag[RT_W-1];

endmodule

// File: rtl/pdh_hist_lane.sv
// One private histogram: read-modify-write with one-deep forwarding,
// bulk clear, and a reduction read port sharing the single read address.
module pdh_hist_lane #(
  parameter int NBINS = 64,
  parameter int AW    = 32,
  localparam int BAW  = $clog2(NBINS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_en,
  input  logic [BAW-1:0] clr_addr,
  input  logic           upd_v,
  input  logic [BAW-1:0] upd_bin,
  input  logic [AW-1:0]  upd_w,
  input  logic [BAW-1:0] red_addr,
  output logic [AW-1:0]  rd_out
);
  logic [AW-1:0]  mem [NBINS];
  logic [AW-1:0]  rd_q;
  logic [BAW-1:0] raddr;

  logic           v1, v2;
  logic [BAW-1:0] b1, b2;
  logic [AW-1:0]  w1, s2;
  logic [AW-1:0]  base, sum1;
  logic           we;
  logic [BAW-1:0] waddr;
  logic [AW-1:0]  wdata;

  assign raddr = upd_v ? upd_bin : red_addr;
  assign base  = (v2 && (b2 == b1)) ? s2 : rd_q;
  assign sum1  = base + w1;
  assign we    = clr_en | v1;
  assign waddr = clr_en ? clr_addr : b1;
  assign wdata = clr_en ? '0 : sum1;

  always_ff @(posedge clk) begin
    rd_q <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= upd_v;
      v2 <= v1 & ~clr_en;
    end
  end

  always_ff @(posedge clk) begin
    b1 <= upd_bin;
    w1 <= upd_w;
    b2 <= b1;
    s2 <= sum1;
  end

  assign rd_out = rd_q;

  // R8: the bulk clear never overlaps a pending histogram update
  p_clear_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(clr_en && (v1 || upd_v)));

endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
  import pdh_pkg::*;
#(
  parameter int UF    = 4,
  parameter int NBINS = 64,
  parameter int N_MAX = 16,
  parameter int DRAIN = 25,
  localparam int PAW  = $clog2(N_MAX),
  localparam int BAW  = $clog2(NBINS),
  localparam int CNT_W = $clog2(N_MAX + UF + 2) + 1,
  localparam int CTW  = $clog2(NBINS + DRAIN + 4) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] n_in,
  output logic             busy,
  output logic             done,
  output logic             clr_en,
  output logic [BAW-1:0]   clr_addr,
  output logic [UF-1:0]    iss_v,
  output logic [PAW-1:0]   iss_j,
  output logic [PAW-1:0]   iss_i,
  output logic [BAW-1:0]   red_addr,
  output logic             res_we,
  output logic [BAW-1:0]   res_addr
);
  localparam logic [CNT_W-1:0] UF_C = CNT_W'(UF);

  pdh_state_e       state;
  logic [CNT_W-1:0] n_q, j, i;
  logic [CTW-1:0]   cnt;
  logic             red_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      n_q      <= '0;
      j        <= '0;
      i        <= '0;
      cnt      <= '0;
      iss_v    <= '0;
      iss_j    <= '0;
      iss_i    <= '0;
      clr_en   <= 1'b0;
      clr_addr <= '0;
      red_v    <= 1'b0;
      red_addr <= '0;
      res_we   <= 1'b0;
      res_addr <= '0;
    end else begin
      iss_v    <= '0;
      clr_en   <= 1'b0;
      red_v    <= 1'b0;
      res_we   <= red_v;
      res_addr <= red_addr;
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            n_q   <= n_in;
            cnt   <= '0;
            state <= ST_CLR;
          end
        end
        ST_CLR: begin
          clr_en   <= 1'b1;
          clr_addr <= cnt[BAW-1:0];
          if (cnt == CTW'(NBINS - 1)) begin
            state <= ST_PAIR;
            j     <= '0;
            i     <= CNT_W'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAIR: begin
          if (j + 1'b1 >= n_q) begin
            state <= ST_DRAIN;
            cnt   <= '0;
          end else if (n_q - i >= UF_C) begin
            iss_v <= '1;
            iss_j <= j[PAW-1:0];
            iss_i <= i[PAW-1:0];
            i     <= i + UF_C;
          end else if (i < n_q) begin
            iss_v <= UF'(1);
            iss_j <= j[PAW-1:0];
            iss_i <= i[PAW-1:0];
            i     <= i + 1'b1;
          end else begin
            j <= j + 1'b1;
            i <= j + CNT_W'(2);
          end
        end
        ST_DRAIN: begin
          if (cnt == CTW'(DRAIN)) begin
            state <= ST_RED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RED: begin
          if (cnt < CTW'(NBINS)) begin
            red_v    <= 1'b1;
            red_addr <= cnt[BAW-1:0];
          end
          if (cnt == CTW'(NBINS + 2)) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: every issued partner follows its test particle and lies inside the count
  p_partner_order_r3: assert property (@(posedge clk) disable iff (rst)
    (|iss_v) |-> ((iss_i > iss_j) && (CNT_W'(iss_i) < n_q)));

  // R4: a full group is only issued when UF partners really remain
  p_full_group_r4: assert property (@(posedge clk) disable iff (rst)
    (&iss_v) |-> ((n_q - CNT_W'(iss_i)) >= UF_C));

  // R5: a partial issue is a single partner on lane 0 from a short remainder
  p_remainder_single_r5: assert property (@(posedge clk) disable iff (rst)
    ((|iss_v) && !(&iss_v)) |-> ((iss_v == UF'(1)) && ((n_q - CNT_W'(iss_i)) < UF_C)));

  // R9: an accepted start reports busy and withdraws done on the next cycle
  p_start_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  // R9: done and busy are never high together
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/pdh_engine.sv
module pdh_engine #(
  parameter int N_MAX = 16,
  parameter int UF    = 4,
  parameter int NBINS = 64,
  parameter int CW    = 16,
  parameter int WW    = 8,
  parameter int AW    = 32,
  localparam int PAW  = $clog2(N_MAX),
  localparam int BAW  = $clog2(NBINS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_we,
  input  logic [PAW-1:0] ld_addr,
  input  logic [CW-1:0]  ld_x,
  input  logic [CW-1:0]  ld_y,
  input  logic [CW-1:0]  ld_z,
  input  logic [WW-1:0]  ld_w,
  input  logic           start,
  input  logic [PAW:0]   n_part,
  output logic           busy,
  output logic           done,
  input  logic [BAW-1:0] rd_addr,
  output logic [AW-1:0]  rd_data
);
  localparam int SQ_W  = 2 * CW + 2;
  localparam int RT_W  = SQ_W / 2;
  localparam int PW_W  = 2 * WW;
  localparam int DRAIN = RT_W + 8;
  localparam int CNT_W = $clog2(N_MAX + UF + 2) + 1;

  function automatic logic [CW-1:0] absd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // particle store
  logic [CW-1:0]        px [N_MAX];
  logic [CW-1:0]        py [N_MAX];
  logic [CW-1:0]        pz [N_MAX];
  logic signed [WW-1:0] pw [N_MAX];

  always_ff @(posedge clk) begin
    if (ld_we) begin
      px[ld_addr] <= ld_x;
      py[ld_addr] <= ld_y;
      pz[ld_addr] <= ld_z;
      pw[ld_addr] <= ld_w;
    end
  end

  // sequencer
  logic           clr_en;
  logic [BAW-1:0] clr_addr;
  logic [UF-1:0]  iss_v;
  logic [PAW-1:0] iss_j, iss_i;
  logic [BAW-1:0] red_addr, res_addr;
  logic           res_we;

  pdh_ctrl #(.UF(UF), .NBINS(NBINS), .N_MAX(N_MAX), .DRAIN(DRAIN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .n_in     (CNT_W'(n_part)),
    .busy     (busy),
    .done     (done),
    .clr_en   (clr_en),
    .clr_addr (clr_addr),
    .iss_v    (iss_v),
    .iss_j    (iss_j),
    .iss_i    (iss_i),
    .red_addr (red_addr),
    .res_we   (res_we),
    .res_addr (res_addr)
  );

  logic [UF-1:0][AW-1:0] lane_rd;

  for (genvar k = 0; k < UF; k++) begin : g_lane
    logic [PAW-1:0]        pidx;
    logic                  va, vb, vs, in_rng;
    logic [CW-1:0]         dxa, dya, dza;
    logic signed [PW_W-1:0] wa;
    logic [2*CW-1:0]       sqx, sqy, sqz;
    logic [SQ_W-1:0]       sqb;
    logic [PW_W-1:0]       wb, ws;
    logic [RT_W-1:0]       rs;
    logic [AW-1:0]         wext;

    assign pidx = iss_i + PAW'(k);

    always_ff @(posedge clk) begin
      if (rst) begin
        va <= 1'b0;
        vb <= 1'b0;
      end else begin
        va <= iss_v[k];
        vb <= va;
      end
    end

    always_ff @(posedge clk) begin
      dxa <= absd(px[iss_j], px[pidx]);
      dya <= absd(py[iss_j], py[pidx]);
      dza <= absd(pz[iss_j], pz[pidx]);
      wa  <= pw[iss_j] * pw[pidx];
    end

    assign sqx = dxa * dxa;
    assign sqy = dya * dya;
    assign sqz = dza * dza;

    always_ff @(posedge clk) begin
      sqb <= {2'b00, sqx} + {2'b00, sqy} + {2'b00, sqz};
      wb  <= wa;
    end

    pdh_isqrt #(.IN_W(SQ_W), .TAG_W(PW_W)) u_root (
      .clk      (clk),
      .rst      (rst),
      .in_v     (vb),
      .in_rad   (sqb),
      .in_tag   (wb),
      .out_v    (vs),
      .out_root (rs),
      .out_tag  (ws)
    );

    assign in_rng = (rs < RT_W'(NBINS));
    assign wext   = {{(AW-PW_W){ws[PW_W-1]}}, ws};

    pdh_hist_lane #(.NBINS(NBINS), .AW(AW)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .clr_en   (clr_en),
      .clr_addr (clr_addr),
      .upd_v    (vs & in_rng),
      .upd_bin  (rs[BAW-1:0]),
      .upd_w    (wext),
      .red_addr (red_addr),
      .rd_out   (lane_rd[k])
    );
  end

  // lane-to-result reduction
  logic [AW-1:0] red_sum;
  always_comb begin
    red_sum = '0;
    for (int k = 0; k < UF; k++) red_sum = red_sum + lane_rd[k];
  end

  logic [AW-1:0] res_mem [NBINS];
  always_ff @(posedge clk) begin
    if (res_we) res_mem[res_addr] <= red_sum;
    rd_data <= res_mem[rd_addr];
  end

endmodule

// File: tb/sim_pdh_engine.sv
module sim_pdh_engine;
  localparam int CLK_P = 10;
  localparam int N  = 16;
  localparam int UF = 4;
  localparam int NB = 64;
  localparam int CW = 16;
  localparam int WW = 8;
  localparam int AW = 32;
  localparam int PAW = $clog2(N);
  localparam int BAW = $clog2(NB);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_we = 1'b0;
  logic [PAW-1:0] ld_addr = '0;
  logic [CW-1:0]  ld_x = '0, ld_y = '0, ld_z = '0;
  logic [WW-1:0]  ld_w = '0;
  logic           start = 1'b0;
  logic [PAW:0]   n_part = '0;
  logic           busy, done;
  logic [BAW-1:0] rd_addr = '0;
  logic [AW-1:0]  rd_data;

  pdh_engine #(.N_MAX(N), .UF(UF), .NBINS(NB), .CW(CW), .WW(WW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_x(ld_x), .ld_y(ld_y), .ld_z(ld_z), .ld_w(ld_w),
    .start(start), .n_part(n_part), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int errs = 0;
  int checks = 0;
  int unsigned seed = 32'd12345;
  longint bx [N];
  longint by [N];
  longint bz [N];
  longint bw [N];
  longint exp_h [NB];

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 8);
  endfunction

  function automatic longint isqrt(input longint v);
    longint r = 0;
    for (int b = 17; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint ex);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  task automatic do_run(input int n, input string req);
    longint dx, dy, dz, d;
    for (int b = 0; b < NB; b++) exp_h[b] = 0;
    for (int j = 0; j < n; j++)
      for (int i = j + 1; i < n; i++) begin
        dx = bx[j] - bx[i]; if (dx < 0) dx = -dx;
        dy = by[j] - by[i]; if (dy < 0) dy = -dy;
        dz = bz[j] - bz[i]; if (dz < 0) dz = -dz;
        d = isqrt(dx*dx + dy*dy + dz*dz);
        if (d < NB) exp_h[d] += bw[j] * bw[i];
      end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = PAW'(k);
      ld_x = CW'(bx[k]); ld_y = CW'(by[k]); ld_z = CW'(bz[k]); ld_w = WW'(bw[k]);
    end
    @(negedge clk);
    ld_we = 1'b0;
    n_part = (PAW+1)'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R9 busy after start", {busy, done}, 2);
    begin
      int t = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
    end
    chk(done == 1'b1 && busy == 1'b0, "R9 done after reduction", {busy, done}, 1);
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      rd_addr = BAW'(b);
      @(negedge clk);
      chk(longint'($signed(rd_data)) == exp_h[b], req, longint'($signed(rd_data)), exp_h[b]);
    end
    chk(done == 1'b1, "R9 done held", done, 1);
  endtask

  task automatic fill_cloud(input int span);
    for (int k = 0; k < N; k++) begin
      bx[k] = rnd() % span; by[k] = rnd() % span; bz[k] = rnd() % span;
      bw[k] = longint'(int'(rnd() % 256)) - 128;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset state", {busy, done}, 0);

    // R1 R2: full random cloud at store depth
    fill_cloud(30);
    do_run(16, "R1 R2 cloud n=16");
    // R8 R3: empty count right after a full run must read all zero
    do_run(0, "R8 R3 cleared after n=0");
    do_run(1, "R3 single particle");

    // R4 R5: every remainder of the partner count modulo UF
    for (int n = 2; n <= 13; n++) begin
      fill_cloud(25);
      do_run(n, (n % 4 == 1) ? "R4 R5 sweep full groups" : "R4 R5 sweep with remainder");
    end

    // R7: coincident particles, all pairs hit bin 0 back to back
    for (int k = 0; k < N; k++) begin
      bx[k] = 65535; by[k] = 65535; bz[k] = 65535;
      bw[k] = longint'(int'(rnd() % 256)) - 128;
    end
    do_run(16, "R7 same-bin run");

    // R6: spaced line, only nearest neighbours land in range
    for (int k = 0; k < N; k++) begin
      bx[k] = k * 40; by[k] = 7; bz[k] = 1000;
      bw[k] = (k % 2 == 0) ? 3 : -5;
    end
    do_run(16, "R6 far pairs dropped");

    // R1: coordinates at the top of the range, plus extreme corners
    for (int k = 0; k < N; k++) begin
      bx[k] = 65535 - (rnd() % 20); by[k] = rnd() % 20; bz[k] = 65535 - (rnd() % 20);
      bw[k] = longint'(int'(rnd() % 256)) - 128;
    end
    bx[3] = 0; by[3] = 65535; bz[3] = 0;
    bx[9] = 65535; by[9] = 0; bz[9] = 65535;
    do_run(15, "R1 R6 high coordinates");

    // R10: readout latency, address change shows only after one edge
    @(negedge clk);
    rd_addr = BAW'(0);
    @(negedge clk);
    begin
      logic [AW-1:0] first;
      first = rd_data;
      chk(longint'($signed(first)) == exp_h[0], "R10 bin 0", longint'($signed(first)), exp_h[0]);
      rd_addr = BAW'(5);
      #1;
      chk(rd_data == first, "R10 no change before edge", rd_data, first);
      @(negedge clk);
      chk(longint'($signed(rd_data)) == exp_h[5], "R10 bin 5 after edge", longint'($signed(rd_data)), exp_h[5]);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule